// File: doc/BRIEF.md
# Barrett CRC32 Reduction Unit

This block advances a raw 32-bit reflected CRC by one data word of 32 or 64 bits in a single pass. It does not use a bit-serial loop or an XOR update matrix. It forms a quotient estimate with a carry-less multiply by a precomputed reciprocal of the generator polynomial. It then multiplies that estimate by the polynomial itself and keeps one 32-bit slice of the second product. That slice is the updated CRC.

Two generator polynomials are built in and selected per word. Select 0 gives the Castagnoli polynomial 0x11EDC6F41 by default, and select 1 gives the polynomial used by zlib and Ethernet, 0x104C11DB7. The reciprocal constants are derived from the polynomial parameters at elaboration time.

Updates are raw: the block applies no initial inversion and no final inversion. A caller that wants a standard checksum inverts the CRC before the first word and after the last word. A word is accepted on each cycle that `in_valid` is high, and its result appears with a one-cycle `out_valid` pulse. A parameter places an optional register between the two multipliers.

Top module: `crc_barrett_reduce`

## Requirements
- R1: While reset is held and directly after it is released, out_valid is 0 and out_crc is 0.
- R2: With in_poly=0 and in_wide=0, out_crc equals the raw reflected bit-serial update of in_crc by in_data[31:0], least significant bit first, with reflected polynomial 0x82F63B78.
- R3: With in_poly=0 and in_wide=1, out_crc equals the same update over all 64 bits of in_data, least significant bit first.
- R4: With in_poly=1 and in_wide=0, out_crc equals the raw reflected update by in_data[31:0] with reflected polynomial 0xEDB88320.
- R5: With in_poly=1 and in_wide=1, out_crc equals the raw reflected update by the 64-bit in_data with reflected polynomial 0xEDB88320.
- R6: When in_wide=0, in_data[63:32] has no effect on out_crc.
- R7: out_valid rises exactly 1+PIPE_MID cycles after a cycle with in_valid high. Words on consecutive cycles, with any mix of width and polynomial, give one correct result per cycle in input order.
- R8: Cycles with in_valid low produce no out_valid pulse. Between pulses out_crc holds the last result, whatever the other inputs do.
- R9: A zero operand gives a zero result. In 32-bit mode with in_crc equal to in_data[31:0], out_crc is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Word present this cycle |
| in_crc | input | 32 | Current CRC value (reflected, raw) |
| in_data | input | 64 | Data word; only bits 31:0 are used in 32-bit mode |
| in_wide | input | 1 | 0: 32-bit word, 1: 64-bit word |
| in_poly | input | 1 | 0: polynomial POLY0, 1: polynomial POLY1 |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_crc | output | 32 | Updated CRC, held between pulses |

## Verification
The two multipliers and the constant table carry no long-lived state. A wrong constant lane, a misplaced product slice or a stale middle register therefore shows up as a wrong out_crc on the same pulse that word produces, 1+PIPE_MID cycles after it enters. A middle register that drops or duplicates a word appears as a missing or extra out_valid pulse, or as results shifted by one slot in a back-to-back stream. Each width and polynomial combination uses its own reciprocal. Each combination is therefore compared separately against a bit-serial model, including a 32-bit word whose upper half is filled with noise.

// File: rtl/crc_barrett_pkg.sv
`timescale 1ns/1ps
package crc_barrett_pkg;

    localparam int CRC_W  = 32;
    localparam int DATA_W = 64;
    localparam int PROD_W = CRC_W + DATA_W;

    localparam logic [CRC_W:0] POLY_CASTAGNOLI = 33'h1_1EDC_6F41;
    localparam logic [CRC_W:0] POLY_ZLIB       = 33'h1_04C1_1DB7;

    // Word between the two multipliers
    typedef struct packed {
        logic             valid;
        logic [CRC_W-1:0] quot;
        logic             poly;
    } mid_t;

    // Registered result
    typedef struct packed {
        logic             valid;
        logic [CRC_W-1:0] crc;
    } res_t;

    function automatic logic [DATA_W-1:0] rev_dw(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
        return r;
    endfunction

    // Reflected polynomial without its leading term
    function automatic logic [CRC_W-1:0] refl_poly(input logic [CRC_W:0] p);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) r[i] = p[CRC_W-1-i];
        return r;
    endfunction

    // floor(x^e / p) over GF(2), returned bit-reversed across 64 bits
    function automatic logic [DATA_W-1:0] recip_refl(input logic [CRC_W:0] p, input int e);
        logic [PROD_W-1:0] s;
        logic [DATA_W-1:0] q;
        s    = '0;
        s[e] = 1'b1;
        q    = '0;
        for (int d = DATA_W - 1; d >= 0; d--) begin
            if (s[d+CRC_W]) begin
                q[d] = 1'b1;
                s    = s ^ ({{(PROD_W-CRC_W-1){1'b0}}, p} << d);
            end
        end
        return rev_dw(q);
    endfunction

endpackage

// File: rtl/crc_barrett_consts.sv
`timescale 1ns/1ps
module crc_barrett_consts
    import crc_barrett_pkg::*;
#(
    parameter logic [CRC_W:0] POLY0 = POLY_CASTAGNOLI,
    parameter logic [CRC_W:0] POLY1 = POLY_ZLIB
) (
    input  logic              poly_a,
    input  logic              wide_a,
    input  logic              poly_b,
    output logic [DATA_W-1:0] k_recip,
    output logic [CRC_W-1:0]  k_poly
);
    // Quotient exponents: 32-bit words use x^63, 64-bit words use x^95
    localparam int EXP_NARROW = 2 * CRC_W - 1;
    localparam int EXP_WIDE   = CRC_W + DATA_W - 1;

    localparam logic [DATA_W-1:0] K0_N = recip_refl(POLY0, EXP_NARROW);
    localparam logic [DATA_W-1:0] K0_W = recip_refl(POLY0, EXP_WIDE);
    localparam logic [DATA_W-1:0] K1_N = recip_refl(POLY1, EXP_NARROW);
    localparam logic [DATA_W-1:0] K1_W = recip_refl(POLY1, EXP_WIDE);
    localparam logic [CRC_W-1:0]  RP0  = refl_poly(POLY0);
    localparam logic [CRC_W-1:0]  RP1  = refl_poly(POLY1);

    always_comb begin
        if (poly_a) k_recip = wide_a ? K1_W : K1_N;
        else        k_recip = wide_a ? K0_W : K0_N;
        k_poly = poly_b ? RP1 : RP0;
    end

endmodule

// File: rtl/crc_clmul_slice.sv
`timescale 1ns/1ps
module crc_clmul_slice #(
    parameter int AW = 64,
    parameter int BW = 64,
    parameter int LO = 32,
    parameter int OW = 32
) (
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [OW-1:0] p
);
    // Product bits LO .. LO+OW-1 of the carry-less product a*b
    for (genvar k = 0; k < OW; k++) begin : g_bit
        logic [AW-1:0] terms;
        for (genvar i = 0; i < AW; i++) begin : g_term
            localparam int J = LO + k - i;
            if (J >= 0 && J < BW) begin : g_on
                assign terms[i] = a[i] & b[J];
            end else begin : g_off
                assign terms[i] = 1'b0;
            end
        end
        assign p[k] = ^terms;
    end

    always_comb begin
        if (a == '0) begin
            // R9
            zero_prod_chk: assert (p == '0)
                else $error("carry-less slice nonzero for zero operand");
        end
    end

endmodule

// File: rtl/crc_barrett_reduce.sv
`timescale 1ns/1ps
module crc_barrett_reduce
    import crc_barrett_pkg::*;
#(
    parameter logic [CRC_W:0] POLY0    = POLY_CASTAGNOLI,
    parameter logic [CRC_W:0] POLY1    = POLY_ZLIB,
    parameter bit             PIPE_MID = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CRC_W-1:0]  in_crc,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_wide,
    input  logic              in_poly,
    output logic              out_valid,
    output logic [CRC_W-1:0]  out_crc
);
    localparam int HI_W = DATA_W - CRC_W;

    logic [DATA_W-1:0] opnd;
    logic [DATA_W-1:0] k_recip;
    logic [CRC_W-1:0]  k_poly;
    logic [CRC_W-1:0]  quot_now;
    logic              valid2;
    logic              poly2;
    logic [CRC_W-1:0]  quot2;
    logic [CRC_W-1:0]  crc2;
    res_t              res_d, res_q;

    // Operand: CRC folded into the low half, upper half only for 64-bit words
    always_comb begin
        opnd[CRC_W-1:0]      = in_data[CRC_W-1:0] ^ in_crc;
        opnd[DATA_W-1:CRC_W] = in_wide ? in_data[DATA_W-1:CRC_W] : {HI_W{1'b0}};
    end

    crc_barrett_consts #(
        .POLY0 (POLY0),
        .POLY1 (POLY1)
    ) u_consts (
        .poly_a  (in_poly),
        .wide_a  (in_wide),
        .poly_b  (poly2),
        .k_recip (k_recip),
        .k_poly  (k_poly)
    );

    // Stage 1: only product bits 63:32 feed stage 2
    crc_clmul_slice #(
        .AW (DATA_W),
        .BW (DATA_W),
        .LO (CRC_W),
        .OW (CRC_W)
    ) u_mul_quot (
        .a (opnd),
        .b (k_recip),
        .p (quot_now)
    );

    if (PIPE_MID) begin : g_mid_reg
        mid_t mid_d, mid_q;

        always_comb begin
            mid_d.valid = in_valid;
            mid_d.quot  = in_valid ? quot_now : mid_q.quot;
            mid_d.poly  = in_valid ? in_poly  : mid_q.poly;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mid_q <= '0;
            else        mid_q <= mid_d;
        end

        assign valid2 = mid_q.valid;
        assign quot2  = mid_q.quot;
        assign poly2  = mid_q.poly;
    end else begin : g_mid_wire
        assign valid2 = in_valid;
        assign quot2  = quot_now;
        assign poly2  = in_poly;
    end

    // Stage 2: quotient times reflected P (bits 32:1 of the high constant);
    // result lane 64..95 of the full product sits at bits 62:31 here
    crc_clmul_slice #(
        .AW (CRC_W),
        .BW (CRC_W),
        .LO (CRC_W - 1),
        .OW (CRC_W)
    ) u_mul_poly (
        .a (quot2),
        .b (k_poly),
        .p (crc2)
    );

    always_comb begin
        res_d.valid = valid2;
        res_d.crc   = valid2 ? crc2 : res_q.crc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_crc   = res_q.crc;

    if (PIPE_MID) begin : g_chk_two
        // R7
        latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> ##1 out_valid);
        // R8
        no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> $past(in_valid, 2));
    end else begin : g_chk_one
        // R7
        latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        // R8
        no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> $past(in_valid));
    end

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_crc));

endmodule

// File: tb/crc_barrett_reduce_tb.sv
`timescale 1ns/1ps
module crc_barrett_reduce_tb;

    localparam bit PIPE = 1'b1;
    localparam int LAT  = PIPE ? 2 : 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_crc = '0;
    logic [63:0] in_data = '0;
    logic        in_wide = 1'b0;
    logic        in_poly = 1'b0;
    logic        out_valid;
    logic [31:0] out_crc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    crc_barrett_reduce #(.PIPE_MID(PIPE)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_crc(in_crc),
        .in_data(in_data), .in_wide(in_wide), .in_poly(in_poly),
        .out_valid(out_valid), .out_crc(out_crc)
    );

    function automatic logic [31:0] model(input logic [31:0] c, input logic [63:0] d,
                                          input bit wide, input bit poly);
        logic [31:0] rp;
        logic        fb;
        int          n;
        rp = poly ? 32'hEDB8_8320 : 32'h82F6_3B78;
        n  = wide ? 64 : 32;
        for (int i = 0; i < n; i++) begin
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb) c = c ^ rp;
        end
        return c;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic one_word(input logic [31:0] c, input logic [63:0] d, input bit wide,
                            input bit poly, input string tag);
        logic [31:0] e;
        e = model(c, d, wide, poly);
        @(negedge clk);
        in_valid = 1'b1; in_crc = c; in_data = d; in_wide = wide; in_poly = poly;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        chk(out_valid === 1'b1, {tag, " valid"}, {31'd0, out_valid}, 32'd1);
        chk(out_crc === e, tag, out_crc, e);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1 valid in reset", {31'd0, out_valid}, 32'd0);
        chk(out_crc === 32'd0, "R1 crc in reset", out_crc, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 valid after reset", {31'd0, out_valid}, 32'd0);
        chk(out_crc === 32'd0, "R1 crc after reset", out_crc, 32'd0);
    endtask

    task automatic t_random(input bit wide, input bit poly, input string tag);
        for (int i = 0; i < 12; i++) begin
            one_word($urandom, {$urandom, $urandom}, wide, poly, tag);
        end
    endtask

    task automatic t_upper_ignored();
        logic [31:0] c;
        logic [31:0] d;
        for (int i = 0; i < 6; i++) begin
            c = $urandom;
            d = $urandom;
            one_word(c, {$urandom | 32'h1, d}, 1'b0, i[0], "R6 upper half ignored");
        end
    endtask

    task automatic t_corners();
        logic [31:0] v;
        v = $urandom;
        one_word(v, {32'hFFFF_FFFF, v}, 1'b0, 1'b0, "R9 crc equals data C");
        chk(out_crc === 32'd0, "R9 zero result C", out_crc, 32'd0);
        one_word(v, {32'h1234_5678, v}, 1'b0, 1'b1, "R9 crc equals data Z");
        chk(out_crc === 32'd0, "R9 zero result Z", out_crc, 32'd0);
        one_word(32'd0, 64'd0, 1'b1, 1'b1, "R9 all zero wide");
        one_word(32'hFFFF_FFFF, 64'd0, 1'b1, 1'b0, "R3 ones crc zero data");
        one_word(32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, "R5 all ones");
        one_word(32'd0, 64'h8000_0000_0000_0000, 1'b1, 1'b0, "R3 top bit only");
        one_word(32'd1, 64'd0, 1'b0, 1'b1, "R4 low bit crc");
        one_word(32'h8000_0000, 64'd0, 1'b0, 1'b0, "R2 high bit crc");
    endtask

    task automatic t_stream();
        localparam int N = 10;
        logic [31:0] exp_q [N];
        logic [31:0] c;
        logic [63:0] d;
        bit          w;
        bit          p;
        for (int t = 0; t < N + LAT; t++) begin
            @(negedge clk);
            if (t >= LAT) begin
                chk(out_valid === 1'b1, "R7 stream valid", {31'd0, out_valid}, 32'd1);
                chk(out_crc === exp_q[t-LAT], "R7 stream order", out_crc, exp_q[t-LAT]);
            end
            if (t < N) begin
                c = $urandom; d = {$urandom, $urandom};
                w = t[0]; p = t[1];
                exp_q[t] = model(c, d, w, p);
                in_valid = 1'b1; in_crc = c; in_data = d; in_wide = w; in_poly = p;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk(out_valid === 1'b0, "R7 stream ends", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_hold();
        logic [31:0] last;
        one_word($urandom, {$urandom, $urandom}, 1'b1, 1'b0, "R3 before hold");
        last = out_crc;
        for (int i = 0; i < 6; i++) begin
            in_valid = 1'b0; in_crc = $urandom; in_data = {$urandom, $urandom};
            in_wide = i[0]; in_poly = i[1];
            @(negedge clk);
            chk(out_valid === 1'b0, "R8 no pulse when idle", {31'd0, out_valid}, 32'd0);
            chk(out_crc === last, "R8 result held", out_crc, last);
        end
    endtask

    initial begin
        t_reset();
        t_random(1'b0, 1'b0, "R2 C narrow");
        t_random(1'b1, 1'b0, "R3 C wide");
        t_random(1'b0, 1'b1, "R4 Z narrow");
        t_random(1'b1, 1'b1, "R5 Z wide");
        t_upper_ignored();
        t_corners();
        t_stream();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule